// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Controller

This block is a synchronous, cycle-level model of a byte-wide SRAM with a shadow nonvolatile copy. Each access is presented as one strobe cycle with chip select, write enable, output enable, an address and write data. Reads and writes go to the working SRAM. The block also watches the stream of reads for a fixed, ordered run of six addresses. When that run completes, it launches a bulk copy. One ending copies the SRAM into the shadow (STORE). The other ending copies the shadow back into the SRAM (RECALL).

A separate active-low hardware store request also starts a STORE. It does so only when the SRAM has been written since the last completed copy; otherwise it is skipped. In either case the block then stays held until the request is released. A copy moves one word per clock and then runs a few extra tail cycles. During the whole copy, `busy` is high, accesses are dropped and no read data is driven.

The full address is 13 bits and is used to match the sequence. The array holds 2**MEM_AW words and is indexed by the low MEM_AW address bits. High-impedance output is modelled as `dout_en` low with `dout` at zero.

Top module: `nvsram_ctrl`

## Requirements
- R1: An access cycle (acc_stb high) with cs_n high, or any clock without acc_stb, changes no stored word and drives no data.
- R2: An accepted read (cs_n low, we_n high) with oe_n low raises dout_en for exactly the next cycle, with dout equal to the word at address bits [MEM_AW-1:0]. With oe_n high, no data is driven.
- R3: An accepted write (cs_n low, we_n low) stores din at address bits [MEM_AW-1:0] and sets unsaved.
- R4: Six accepted reads to 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and 0x0F0F, in that order, start a STORE (SRAM copied to shadow). Each of these reads still returns the SRAM word.
- R5: The same first five addresses followed by 0x0F0E start a RECALL (shadow copied to SRAM).
- R6: An accepted write cancels a partial sequence. A read that does not match the next expected address also cancels it, except that a read of 0x0000 restarts it at step one.
- R7: busy rises in the second clock after the starting trigger and stays high for 2**MEM_AW + TAIL_CYC cycles. While busy is high, accesses are ignored and dout_en is low.
- R8: A completed STORE or RECALL clears unsaved.
- R9: While hw_store_n is low, dout_en is low. A low hw_store_n starts a STORE only when unsaved is set. After the STORE, or the skip, all accesses are ignored until hw_store_n returns high.
- R10: oe_n has no influence on whether a sequence starts a STORE or RECALL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_stb | input | 1 | Marks a clock as one access cycle |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| addr | input | 13 | Word address |
| din | input | DATA_W | Write data |
| hw_store_n | input | 1 | Active-low hardware store request |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | Read data is being driven |
| busy | output | 1 | STORE or RECALL in progress |
| unsaved | output | 1 | SRAM written since last completed copy |

## Verification
A sequence matcher stuck at the wrong step shows up as a missing or spurious `busy` pulse, two clocks after the sixth read of a run. That is checked with runs broken by a write, by a stray read and by an early restart. A copy that uses the wrong direction or the wrong index is invisible until a later read, so each STORE is followed by an overwrite and a RECALL and then read back. A wrong written-flag shows up directly on `unsaved`. It also shows up indirectly when a hardware request produces or fails to produce `busy`. An off-by-one in the copy counter shows up as a `busy` width one cycle away from 2**MEM_AW + TAIL_CYC.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
   localparam int ADDR_W = 13;

   typedef enum logic [1:0] {
      OP_NONE   = 2'd0,
      OP_STORE  = 2'd1,
      OP_RECALL = 2'd2
   } nv_op_e;

   localparam logic [ADDR_W-1:0] LAST_STORE  = 13'h0F0F;
   localparam logic [ADDR_W-1:0] LAST_RECALL = 13'h0F0E;

   // leading five addresses of the unlock run; order is behaviour
   function automatic logic [ADDR_W-1:0] lead_addr(input int idx);
      case (idx)
         0:       lead_addr = 13'h0000;
         1:       lead_addr = 13'h1555;
         2:       lead_addr = 13'h0AAA;
         3:       lead_addr = 13'h1FFF;
         default: lead_addr = 13'h10F0;
      endcase
   endfunction
endpackage

// File: rtl/nvs_seq_match.sv
module nvs_seq_match
   import nvs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_acc,
   input  logic              wr_acc,
   input  logic [ADDR_W-1:0] addr,
   output nv_op_e            start_op
);
   localparam int LEAD_N = 5;

   logic [2:0] step_q;
   logic [7:0] lead_hit;
   logic       is_zero;

   for (genvar gi = 0; gi < 8; gi++) begin : g_hit
      if (gi < LEAD_N) begin : g_cmp
         assign lead_hit[gi] = (addr == lead_addr(gi));
      end else begin : g_pad
         assign lead_hit[gi] = 1'b0;
      end
   end

   assign is_zero = (addr == '0);

   always_comb begin
      start_op = OP_NONE;
      if (rd_acc && step_q == 3'(LEAD_N)) begin
         if (addr == LAST_STORE)       start_op = OP_STORE;
         else if (addr == LAST_RECALL) start_op = OP_RECALL;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q <= '0;
      end else if (wr_acc) begin
         step_q <= '0;
      end else if (rd_acc) begin
         if (step_q == 3'(LEAD_N))
            step_q <= (start_op == OP_NONE && is_zero) ? 3'd1 : 3'd0;
         else if (lead_hit[step_q])
            step_q <= step_q + 3'd1;
         else
            step_q <= is_zero ? 3'd1 : 3'd0;
      end
   end
endmodule

// File: rtl/nvs_xfer_engine.sv
module nvs_xfer_engine
   import nvs_pkg::*;
#(
   parameter int MEM_AW   = 10,
   parameter int TAIL_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  nv_op_e            start_op,
   output logic              busy,
   output logic              dir_store,
   output logic              copy_en,
   output logic [MEM_AW-1:0] copy_idx,
   output logic              done
);
   localparam int DEPTH = 2 ** MEM_AW;
   localparam int TOTAL = DEPTH + TAIL_CYC;
   localparam int CW    = $clog2(TOTAL + 1);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
   localparam logic [CW-1:0] LAST_C  = CW'(TOTAL - 1);

   if (TAIL_CYC < 0) begin : g_bad_tail
      $error("TAIL_CYC must not be negative");
   end

   logic [CW-1:0] cnt_q;
   nv_op_e        op_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
         op_q  <= OP_NONE;
      end else if (!busy) begin
         if (start_op != OP_NONE) begin
            busy  <= 1'b1;
            cnt_q <= '0;
            op_q  <= start_op;
         end
      end else if (cnt_q == LAST_C) begin
         busy <= 1'b0;
         op_q <= OP_NONE;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign dir_store = (op_q == OP_STORE);
   assign copy_en   = busy && (cnt_q < DEPTH_C);
   assign copy_idx  = cnt_q[MEM_AW-1:0];
   assign done      = busy && (cnt_q == LAST_C);
endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
   parameter int DATA_W = 8,
   parameter int MEM_AW = 10
) (
   input  logic              clk,
   input  logic              acc_we,
   input  logic              acc_re,
   input  logic [MEM_AW-1:0] acc_addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] rd_data,
   input  logic              copy_en,
   input  logic              dir_store,
   input  logic [MEM_AW-1:0] copy_idx
);
   localparam int DEPTH = 2 ** MEM_AW;

   logic [DATA_W-1:0] sram   [DEPTH];
   logic [DATA_W-1:0] shadow [DEPTH];

   always_ff @(posedge clk) begin
      if (copy_en && !dir_store)
         sram[copy_idx] <= shadow[copy_idx];
      else if (acc_we)
         sram[acc_addr] <= din;
   end

   always_ff @(posedge clk) begin
      if (copy_en && dir_store)
         shadow[copy_idx] <= sram[copy_idx];
   end

   always_ff @(posedge clk) begin
      if (acc_re)
         rd_data <= sram[acc_addr];
   end
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
   import nvs_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int MEM_AW   = 10,
   parameter int TAIL_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_stb,
   input  logic              cs_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [12:0]       addr,
   input  logic [DATA_W-1:0] din,
   input  logic              hw_store_n,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic              busy,
   output logic              unsaved
);
   if (MEM_AW < 2 || MEM_AW > ADDR_W) begin : g_bad_aw
      $error("MEM_AW must lie between 2 and the address width");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("DATA_W must be positive");
   end

   nv_op_e            seq_op, pend_op;
   logic              hw_hold, rd_q, gate_open, acc_ok, rd_acc, wr_acc, hw_trig;
   logic              dir_store, copy_en, eng_done;
   logic [MEM_AW-1:0] copy_idx;
   logic [DATA_W-1:0] rd_data;

   assign gate_open = !busy && (pend_op == OP_NONE) && hw_store_n && !hw_hold;
   assign acc_ok    = acc_stb && !cs_n && gate_open;
   assign rd_acc    = acc_ok && we_n;
   assign wr_acc    = acc_ok && !we_n;
   assign hw_trig   = !hw_store_n && !hw_hold && !busy && (pend_op == OP_NONE);

   nvs_seq_match u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_acc   (rd_acc),
      .wr_acc   (wr_acc),
      .addr     (addr),
      .start_op (seq_op)
   );

   nvs_xfer_engine #(.MEM_AW(MEM_AW), .TAIL_CYC(TAIL_CYC)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_op  (pend_op),
      .busy      (busy),
      .dir_store (dir_store),
      .copy_en   (copy_en),
      .copy_idx  (copy_idx),
      .done      (eng_done)
   );

   nvs_array #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_mem (
      .clk       (clk),
      .acc_we    (wr_acc),
      .acc_re    (rd_acc),
      .acc_addr  (addr[MEM_AW-1:0]),
      .din       (din),
      .rd_data   (rd_data),
      .copy_en   (copy_en),
      .dir_store (dir_store),
      .copy_idx  (copy_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_op <= OP_NONE;
         hw_hold <= 1'b0;
         unsaved <= 1'b0;
         rd_q    <= 1'b0;
      end else begin
         pend_op <= OP_NONE;
         if (seq_op != OP_NONE)
            pend_op <= seq_op;
         else if (hw_trig && unsaved)
            pend_op <= OP_STORE;

         if (hw_trig)
            hw_hold <= 1'b1;
         else if (hw_hold && hw_store_n && !busy && pend_op == OP_NONE)
            hw_hold <= 1'b0;

         if (eng_done)
            unsaved <= 1'b0;
         else if (wr_acc)
            unsaved <= 1'b1;

         rd_q <= rd_acc && !oe_n;
      end
   end

   assign dout_en = rd_q && hw_store_n && !busy;
   assign dout    = dout_en ? rd_data : '0;
endmodule

// File: rtl/nvsram_ctrl_chk.sv
module nvsram_ctrl_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_stb,
   input logic              cs_n,
   input logic              we_n,
   input logic              oe_n,
   input logic              hw_store_n,
   input logic [DATA_W-1:0] dout,
   input logic              dout_en,
   input logic              busy,
   input logic              unsaved
);
   AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_stb && cs_n) |=> !dout_en);                              // R1
   AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_stb && oe_n) |=> !dout_en);                              // R2
   AST_NO_DATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_en |-> (dout == '0));                                   // R2
   AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unsaved) |-> $past(acc_stb && !cs_n && !we_n));         // R3
   AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !dout_en);                                           // R7
   AST_COPY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !unsaved);                                    // R8
   AST_HW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_store_n |-> !dout_en);                                    // R9
endmodule

bind nvsram_ctrl nvsram_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_stb    (acc_stb),
   .cs_n       (cs_n),
   .we_n       (we_n),
   .oe_n       (oe_n),
   .hw_store_n (hw_store_n),
   .dout       (dout),
   .dout_en    (dout_en),
   .busy       (busy),
   .unsaved    (unsaved)
);

// File: tb/nvsram_ctrl_test.sv
module nvsram_ctrl_test;
   localparam int DW    = 8;
   localparam int MAW   = 10;
   localparam int TAIL  = 4;
   localparam int DEPTH = 2 ** MAW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_stb = 1'b0, cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [12:0]   addr = '0;
   logic [DW-1:0] din = '0;
   logic          hw_store_n = 1'b1;
   logic [DW-1:0] dout;
   logic          dout_en, busy, unsaved;

   nvsram_ctrl #(.DATA_W(DW), .MEM_AW(MAW), .TAIL_CYC(TAIL)) uut (
      .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .cs_n(cs_n), .we_n(we_n),
      .oe_n(oe_n), .addr(addr), .din(din), .hw_store_n(hw_store_n),
      .dout(dout), .dout_en(dout_en), .busy(busy), .unsaved(unsaved)
   );

   always #10ns clk = ~clk;

   int            n_chk = 0, n_fail = 0;
   logic [DW-1:0] m_sram [DEPTH];
   logic [DW-1:0] m_shad [DEPTH];
   logic [DW-1:0] expq [$];
   string         tagq [$];
   string         cur_tag = "R1";

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever data is driven
   always @(negedge clk) begin
      if (rst_n && dout_en) begin
         if (expq.size() == 0) begin
            check(0, {cur_tag, " unexpected data"}, int'(dout), -1);
         end else begin
            logic [DW-1:0] e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            check(dout == e, t, int'(dout), int'(e));
         end
      end
   end

   // one access cycle; live=1 means the bench expects it accepted
   task automatic access(input bit cs, input bit we, input bit oe, input logic [12:0] a,
                         input logic [DW-1:0] d, input bit live, input string tag);
      @(negedge clk);
      cur_tag = tag;
      acc_stb = 1'b1; cs_n = cs; we_n = we; oe_n = oe; addr = a; din = d;
      if (live && !cs) begin
         if (!we) m_sram[a[MAW-1:0]] = d;
         else if (!oe) begin
            expq.push_back(m_sram[a[MAW-1:0]]);
            tagq.push_back(tag);
         end
      end
      @(negedge clk);
      acc_stb = 1'b0; cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic wr(input logic [12:0] a, input logic [DW-1:0] d, input bit live, input string tag);
      access(1'b0, 1'b0, 1'b1, a, d, live, tag);
   endtask

   task automatic rd(input logic [12:0] a, input bit live, input string tag);
      access(1'b0, 1'b1, 1'b0, a, '0, live, tag);
   endtask

   task automatic run_seq(input logic [12:0] last, input bit oe, input string tag);
      access(1'b0, 1'b1, oe, 13'h0000, '0, 1'b1, tag);
      access(1'b0, 1'b1, oe, 13'h1555, '0, 1'b1, tag);
      access(1'b0, 1'b1, oe, 13'h0AAA, '0, 1'b1, tag);
      access(1'b0, 1'b1, oe, 13'h1FFF, '0, 1'b1, tag);
      access(1'b0, 1'b1, oe, 13'h10F0, '0, 1'b1, tag);
      access(1'b0, 1'b1, oe, last,     '0, 1'b1, tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // waits for busy, returns its width in cycles (0 if it never rose)
   task automatic busy_width(output int w);
      int k;
      w = 0;
      k = 0;
      while (!busy && k < 20) begin @(negedge clk); k++; end
      while (busy && w < 5000) begin @(negedge clk); w++; end
   endtask

   task automatic do_store_model();
      for (int i = 0; i < DEPTH; i++) m_shad[i] = m_sram[i];
   endtask

   task automatic do_recall_model();
      for (int i = 0; i < DEPTH; i++) m_sram[i] = m_shad[i];
   endtask

   bit done = 0;

   initial begin
      #(20ns * 150000);
      if (!done) begin
         check(0, "watchdog", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int w;
      for (int i = 0; i < DEPTH; i++) begin m_sram[i] = '0; m_shad[i] = '0; end
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // reset state
      check(!busy && !dout_en && !unsaved, "R1 reset outputs", {busy, dout_en, unsaved}, 0);

      // clear whole array so copies are fully defined
      for (int i = 0; i < DEPTH; i++) wr(13'(i), '0, 1'b1, "R3");
      idle(2);
      busy_width(w); // not expected; keep alignment
      check(w == 0, "R1 no spurious copy", w, 0);

      wr(13'h010, 8'hA5, 1'b1, "R3");
      wr(13'h020, 8'h3C, 1'b1, "R3");
      wr(13'h1555, 8'h61, 1'b1, "R3");
      wr(13'h0F0F, 8'h72, 1'b1, "R3");
      check(unsaved, "R3 unsaved set", unsaved, 1);
      rd(13'h010, 1'b1, "R2 read");
      rd(13'h020, 1'b1, "R2 read");
      rd(13'h1020, 1'b1, "R2 aliased read");
      // oe_n high: no data
      access(1'b0, 1'b1, 1'b1, 13'h010, '0, 1'b1, "R2 oe high");
      check(!dout_en, "R2 oe high no drive", dout_en, 0);
      // deselected write ignored
      access(1'b1, 1'b0, 1'b1, 13'h010, 8'hFF, 1'b0, "R1 deselect");
      rd(13'h010, 1'b1, "R1 deselected write ignored");

      // STORE sequence
      run_seq(13'h0F0F, 1'b0, "R4 seq read");
      do_store_model();
      busy_width(w);
      check(w == DEPTH + TAIL, "R7 busy width", w, DEPTH + TAIL);
      check(!unsaved, "R8 store clears", unsaved, 0);

      // overwrite, then RECALL with accesses during busy
      wr(13'h010, 8'h77, 1'b1, "R3");
      rd(13'h010, 1'b1, "R3 overwrite");
      check(unsaved, "R3 unsaved after write", unsaved, 1);
      run_seq(13'h0F0E, 1'b0, "R5 seq read");
      do_recall_model();
      idle(2);
      check(busy, "R5 recall busy", busy, 1);
      wr(13'h020, 8'h99, 1'b0, "R7 write in busy");
      rd(13'h020, 1'b0, "R7 read in busy");
      while (busy) @(negedge clk);
      rd(13'h010, 1'b1, "R5 recalled word");
      rd(13'h020, 1'b1, "R7 busy write ignored");
      check(!unsaved, "R8 recall clears", unsaved, 0);

      // R6: write cancels
      wr(13'h010, 8'h5A, 1'b1, "R3");
      rd(13'h0000, 1'b1, "R6");
      rd(13'h1555, 1'b1, "R6");
      rd(13'h0AAA, 1'b1, "R6");
      wr(13'h030, 8'h12, 1'b1, "R6");
      rd(13'h1FFF, 1'b1, "R6");
      rd(13'h10F0, 1'b1, "R6");
      rd(13'h0F0F, 1'b1, "R6");
      busy_width(w);
      check(w == 0, "R6 write cancels", w, 0);
      // stray read cancels
      rd(13'h0000, 1'b1, "R6");
      rd(13'h1555, 1'b1, "R6");
      rd(13'h0AAA, 1'b1, "R6");
      rd(13'h0123, 1'b1, "R6");
      rd(13'h1FFF, 1'b1, "R6");
      rd(13'h10F0, 1'b1, "R6");
      rd(13'h0F0F, 1'b1, "R6");
      busy_width(w);
      check(w == 0, "R6 stray read cancels", w, 0);
      // 0x0000 restarts at step one
      rd(13'h0000, 1'b1, "R6");
      rd(13'h1555, 1'b1, "R6");
      run_seq(13'h0F0F, 1'b0, "R6 restart");
      do_store_model();
      busy_width(w);
      check(w == DEPTH + TAIL, "R6 restart starts store", w, DEPTH + TAIL);

      // R10: sequence with oe_n high still recalls
      wr(13'h010, 8'h00, 1'b1, "R3");
      run_seq(13'h0F0E, 1'b1, "R10");
      do_recall_model();
      busy_width(w);
      check(w == DEPTH + TAIL, "R10 recall with oe high", w, DEPTH + TAIL);
      rd(13'h010, 1'b1, "R10 recalled word");

      // R9: hardware store skipped when clean
      check(!unsaved, "R9 clean before hw", unsaved, 0);
      @(negedge clk); hw_store_n = 1'b0;
      idle(1);
      busy_width(w);
      check(w == 0, "R9 clean hw skipped", w, 0);
      wr(13'h010, 8'hEE, 1'b0, "R9 write while held");
      rd(13'h010, 1'b0, "R9 read while held");
      check(!unsaved, "R9 held write ignored", unsaved, 0);
      @(negedge clk); hw_store_n = 1'b1;
      idle(2);
      rd(13'h010, 1'b1, "R9 after release");

      // R9: hardware store when dirty
      wr(13'h010, 8'hC3, 1'b1, "R3");
      @(negedge clk); hw_store_n = 1'b0;
      do_store_model();
      busy_width(w);
      check(w == DEPTH + TAIL, "R9 dirty hw store", w, DEPTH + TAIL);
      check(!unsaved, "R8 hw store clears", unsaved, 0);
      wr(13'h010, 8'hEE, 1'b0, "R9 held after store");
      @(negedge clk); hw_store_n = 1'b1;
      idle(2);
      rd(13'h010, 1'b1, "R9 held write ignored");
      wr(13'h010, 8'h01, 1'b1, "R3");
      run_seq(13'h0F0E, 1'b0, "R9 recall");
      do_recall_model();
      busy_width(w);
      rd(13'h010, 1'b1, "R9 hw stored word");

      idle(3);
      check(expq.size() == 0, "R2 missing read data", expq.size(), 0);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule